// File: doc/BRIEF.md
# Four-Phase Request/Acknowledge Protocol Monitor

This block observes a four-phase request/acknowledge transfer whose request, acknowledge and data lines are already sampled in the monitor's clock. It does not take part in the transfer and drives nothing back to it. It reports five protocol faults on sticky flags that stay set until reset. It also keeps two saturating coverage counters: one counts request rising edges and one counts acknowledge rising edges.

A tracker with four states follows each transfer: idle, request waiting for an acknowledge, both lines high, and request released while the acknowledge is still high. A programmable limit sets how many cycles an acknowledge may lag its request, and a limit of zero turns that check off. The data bus is captured on the edge where the request is first seen. It is compared on every later edge until the acknowledge is seen.

Top module: `hs_handshake_monitor`

## Requirements
- R1: After reset, all five flags and both counters read zero.
- R2: A request rising while the acknowledge of the previous transfer is still high (request already released) sets `multi_req_o`. A request rising on the same edge that the acknowledge is seen low does not.
- R3: An acknowledge rising while the request is low sets `orphan_ack_o`, unless a pending request is released on that same edge.
- R4: The request falling while it is still waiting for an acknowledge sets `req_drop_o`.
- R5: Take the request first seen high at edge E0 and the acknowledge first seen high at edge E0+k. With a nonzero limit T, `ack_timeout_o` sets at edge E0+T exactly when k > T. With T = 0 it never sets.
- R6: `data_i` is captured at E0. If it differs from that value at any edge E0+1 .. E0+k while the request is high, `data_change_o` sets. Changes after E0+k have no effect.
- R7: `req_count_o` increments by one per request rising edge. `ack_count_o` increments by one per acknowledge rising edge, including acknowledges that have no request.
- R8: Both counters saturate at all ones and hold there.
- R9: Every flag stays set until reset, whatever traffic follows.
- R10: Well-formed four-phase transfers, including back-to-back ones, set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Observed request |
| ack_i | input | 1 | Observed acknowledge |
| data_i | input | DW | Observed data bus |
| timeout_i | input | TW | Acknowledge deadline in cycles, 0 disables |
| multi_req_o | output | 1 | Sticky: new request before previous completed |
| orphan_ack_o | output | 1 | Sticky: acknowledge with no request |
| req_drop_o | output | 1 | Sticky: request withdrawn before acknowledge |
| ack_timeout_o | output | 1 | Sticky: acknowledge missed its deadline |
| data_change_o | output | 1 | Sticky: data moved while request pending |
| req_count_o | output | CW | Saturating request-edge count |
| ack_count_o | output | CW | Saturating acknowledge-edge count |

## Verification
Assertions check the following on every cycle:
- flags never clear once set;
- counters hold when they see no edge and stay pinned at all ones;
- no deadline fault appears while the limit is zero;
- the tracker's waiting states agree with the sampled request and acknowledge levels.

Only the bench scenarios can show the following:
- the exact edge on which a late acknowledge becomes a fault, swept over limits and delays;
- the window in which a data change counts;
- that legal back-to-back transfers stay clean;
- the counting of each rising edge.

// File: rtl/hs_mon_pkg.sv
package hs_mon_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PEND  = 2'd1,
    ST_ACKD  = 2'd2,
    ST_WFALL = 2'd3
  } hs_state_e;

  localparam int unsigned FL_MULTI  = 0;
  localparam int unsigned FL_ORPHAN = 1;
  localparam int unsigned FL_DROP   = 2;
  localparam int unsigned FL_TMO    = 3;
  localparam int unsigned FL_DATA   = 4;
  localparam int unsigned NUM_FLAGS = 5;
endpackage

// File: rtl/hs_fsm.sv
module hs_fsm
  import hs_mon_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          ack_i,
  input  logic [DW-1:0] data_i,
  output logic          req_rise_o,
  output logic          ack_rise_o,
  output logic          arm_o,
  output logic          run_o,
  output logic          multi_o,
  output logic          orphan_o,
  output logic          drop_o,
  output logic          data_err_o
);
  hs_state_e     st_q, st_d;
  logic          req_q, ack_q;
  logic [DW-1:0] data_q;

  assign req_rise_o = req_i & ~req_q;
  assign ack_rise_o = ack_i & ~ack_q;

  always_comb begin
    st_d    = st_q;
    multi_o = 1'b0;
    drop_o  = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (req_i) st_d = ack_i ? ST_ACKD : ST_PEND;
      ST_PEND: begin
        if (ack_i) begin
          st_d = req_i ? ST_ACKD : ST_WFALL;
        end else if (!req_i) begin
          drop_o = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      ST_ACKD:  if (!req_i) st_d = ack_i ? ST_WFALL : ST_IDLE;
      ST_WFALL: begin
        if (req_i && ack_i) begin
          multi_o = 1'b1;
          st_d    = ST_ACKD;
        end else if (!ack_i) begin
          st_d = req_i ? ST_PEND : ST_IDLE;
        end
      end
      default:  st_d = ST_IDLE;
    endcase
  end

  // release of a pending request on the acknowledge edge is legal
  assign orphan_o   = ack_rise_o & ~req_i & (st_q != ST_PEND);
  assign arm_o      = (st_d == ST_PEND) && (st_q != ST_PEND);
  assign run_o      = (st_q == ST_PEND) && req_i && !ack_i;
  assign data_err_o = (st_q == ST_PEND) && req_i && (data_i != data_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      req_q  <= 1'b0;
      ack_q  <= 1'b0;
      data_q <= '0;
    end else begin
      st_q  <= st_d;
      req_q <= req_i;
      ack_q <= ack_i;
      if (arm_o) data_q <= data_i;
    end
  end

  assert_pend_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PEND) |-> req_q);
  assert_wfall_ack_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WFALL) |-> ack_q);
endmodule

// File: rtl/hs_timer.sv
module hs_timer #(
  parameter int unsigned TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          run_i,
  input  logic [TW-1:0] limit_i,
  output logic          expire_o
);
  logic [TW-1:0] cnt_q;
  logic [TW:0]   cnt_inc;

  assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
  assign expire_o = run_i && (limit_i != '0) && (cnt_inc == {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (arm_i)                cnt_q <= '0;
    else if (run_i && !(&cnt_q))   cnt_q <= cnt_inc[TW-1:0];
  end
endmodule

// File: rtl/hs_sat_cnt.sv
module hs_sat_cnt #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (inc_i && !(&cnt_q)) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_cnt_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cnt_q) |=> (&cnt_q));
  assert_cnt_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_q));
endmodule

// File: rtl/hs_sticky.sv
module hs_sticky #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : gen_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[i] <= 1'b0;
      else if (set_i[i]) flag_q[i] <= 1'b1;
    end

    assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_q[i] |=> flag_q[i]);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/hs_handshake_monitor.sv
module hs_handshake_monitor
  import hs_mon_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned TW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          ack_i,
  input  logic [DW-1:0] data_i,
  input  logic [TW-1:0] timeout_i,
  output logic          multi_req_o,
  output logic          orphan_ack_o,
  output logic          req_drop_o,
  output logic          ack_timeout_o,
  output logic          data_change_o,
  output logic [CW-1:0] req_count_o,
  output logic [CW-1:0] ack_count_o
);
  logic                 req_rise, ack_rise, arm, run;
  logic                 multi, orphan, drop, data_err, expire;
  logic [NUM_FLAGS-1:0] set_vec, flags;
  logic [1:0]           inc_vec;
  logic [CW-1:0]        cnt_w [2];

  hs_fsm #(.DW(DW)) u_fsm (
    .clk_i, .rst_ni, .req_i, .ack_i, .data_i,
    .req_rise_o (req_rise),
    .ack_rise_o (ack_rise),
    .arm_o      (arm),
    .run_o      (run),
    .multi_o    (multi),
    .orphan_o   (orphan),
    .drop_o     (drop),
    .data_err_o (data_err)
  );

  hs_timer #(.TW(TW)) u_timer (
    .clk_i, .rst_ni,
    .arm_i    (arm),
    .run_i    (run),
    .limit_i  (timeout_i),
    .expire_o (expire)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[FL_MULTI]  = multi;
    set_vec[FL_ORPHAN] = orphan;
    set_vec[FL_DROP]   = drop;
    set_vec[FL_TMO]    = expire;
    set_vec[FL_DATA]   = data_err;
  end

  hs_sticky #(.N(NUM_FLAGS)) u_sticky (
    .clk_i, .rst_ni,
    .set_i  (set_vec),
    .flag_o (flags)
  );

  assign inc_vec = {ack_rise, req_rise};

  for (genvar c = 0; c < 2; c++) begin : gen_cov
    hs_sat_cnt #(.CW(CW)) u_cnt (
      .clk_i, .rst_ni,
      .inc_i (inc_vec[c]),
      .cnt_o (cnt_w[c])
    );
  end

  assign multi_req_o   = flags[FL_MULTI];
  assign orphan_ack_o  = flags[FL_ORPHAN];
  assign req_drop_o    = flags[FL_DROP];
  assign ack_timeout_o = flags[FL_TMO];
  assign data_change_o = flags[FL_DATA];
  assign req_count_o   = cnt_w[0];
  assign ack_count_o   = cnt_w[1];

  assert_tmo_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((timeout_i == '0) && !ack_timeout_o) |=> !ack_timeout_o);
endmodule

// File: tb/sim_hs_handshake_monitor.sv
module sim_hs_handshake_monitor;
  localparam int unsigned DW = 8;
  localparam int unsigned TW = 4;
  localparam int unsigned CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, ack = 1'b0;
  logic [DW-1:0] data = '0;
  logic [TW-1:0] tmo = '0;
  logic          f_multi, f_orphan, f_drop, f_tmo, f_data;
  logic [CW-1:0] c_req, c_ack;
  int            n_chk = 0, n_fail = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  hs_handshake_monitor #(.DW(DW), .TW(TW), .CW(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ack_i(ack), .data_i(data),
    .timeout_i(tmo), .multi_req_o(f_multi), .orphan_ack_o(f_orphan),
    .req_drop_o(f_drop), .ack_timeout_o(f_tmo), .data_change_o(f_data),
    .req_count_o(c_req), .ack_count_o(c_ack)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req = 1'b0; ack = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // ack first seen k edges after the request; data bumped at negedge chg (0 = never)
  task automatic handshake(int k, int chg);
    @(negedge clk);
    req = 1'b1;
    for (int m = 1; m <= k; m++) begin
      @(negedge clk);
      if (m == chg) data = data + 1'b1;
      if (m == k) ack = 1'b1;
    end
    @(negedge clk);
    req = 1'b0;
    if (chg == k + 1) data = data + 1'b1;
    @(negedge clk);
    ack = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    check("R1 multi", f_multi, 0);
    check("R1 orphan", f_orphan, 0);
    check("R1 drop", f_drop, 0);
    check("R1 tmo", f_tmo, 0);
    check("R1 data", f_data, 0);
    check("R1 req_count", c_req, 0);
    check("R1 ack_count", c_ack, 0);

    handshake(1, 0);
    check("R10 clean flags", {f_multi, f_orphan, f_drop, f_tmo, f_data}, 0);
    check("R7 req_count", c_req, 1);
    check("R7 ack_count", c_ack, 1);

    // R5 sweep of limit and ack delay
    for (int t = 0; t <= 4; t++) begin
      for (int k = 1; k <= 6; k++) begin
        do_reset();
        tmo = TW'(t);
        handshake(k, 0);
        check($sformatf("R5 tmo t=%0d k=%0d", t, k), f_tmo, (t != 0 && k > t) ? 1 : 0);
        check($sformatf("R10 no drop t=%0d k=%0d", t, k), f_drop, 0);
      end
    end
    tmo = '0;

    // R6 data window sweep
    for (int m = 1; m <= 4; m++) begin
      do_reset();
      handshake(3, m);
      check($sformatf("R6 data m=%0d", m), f_data, (m <= 3) ? 1 : 0);
    end

    // R2 illegal re-request with ack still high
    do_reset();
    @(negedge clk); req = 1'b1;
    @(negedge clk); ack = 1'b1;
    @(negedge clk); req = 1'b0;
    @(negedge clk); req = 1'b1;
    @(negedge clk);
    check("R2 multi", f_multi, 1);
    check("R7 req_count after multi", c_req, 2);
    check("R7 ack_count after multi", c_ack, 1);
    req = 1'b0;
    @(negedge clk); ack = 1'b0;
    @(negedge clk);

    // R2/R10 legal back-to-back
    do_reset();
    @(negedge clk); req = 1'b1;
    @(negedge clk); ack = 1'b1;
    @(negedge clk); req = 1'b0;
    @(negedge clk); ack = 1'b0; req = 1'b1;
    @(negedge clk); ack = 1'b1;
    @(negedge clk); req = 1'b0;
    @(negedge clk); ack = 1'b0;
    @(negedge clk);
    check("R2 back-to-back no multi", f_multi, 0);
    check("R10 back-to-back flags", {f_orphan, f_drop, f_tmo, f_data}, 0);
    check("R7 back-to-back counts", {c_req, c_ack}, {CW'(2), CW'(2)});

    // R3 orphan ack, then R9 stickiness
    do_reset();
    @(negedge clk); ack = 1'b1;
    @(negedge clk);
    check("R3 orphan", f_orphan, 1);
    check("R7 orphan ack_count", c_ack, 1);
    check("R7 orphan req_count", c_req, 0);
    ack = 1'b0;
    handshake(2, 0);
    check("R9 orphan sticky", f_orphan, 1);

    // R3 ack with simultaneous request release is legal
    do_reset();
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0; ack = 1'b1;
    @(negedge clk);
    check("R3 no orphan on release", f_orphan, 0);
    check("R4 no drop on release", f_drop, 0);
    ack = 1'b0;
    @(negedge clk);

    // R4 request withdrawn
    do_reset();
    tmo = TW'(2);
    @(negedge clk); req = 1'b1;
    @(negedge clk);
    @(negedge clk); req = 1'b0;
    @(negedge clk);
    check("R4 drop", f_drop, 1);
    check("R5 no tmo after drop", f_tmo, 0);
    tmo = '0;

    // R7/R8 counting up to and past saturation
    do_reset();
    for (int i = 1; i <= 17; i++) begin
      handshake(1, 0);
      check($sformatf("R8 req_count i=%0d", i), c_req, (i < 15) ? i : 15);
      check($sformatf("R8 ack_count i=%0d", i), c_ack, (i < 15) ? i : 15);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule